// File: doc/BRIEF.md
# Genotype Crossover and Mutation Unit

This block produces two offspring genotypes from a pair of parent genotypes for a hardware evolutionary search. Each genotype is a fixed-length string of 16-bit words held in word-addressed buffers outside the block. After a start pulse the unit reads both parents one address per clock. For every address it either keeps each parent's word or exchanges the pair of words as a whole. It then inverts each bit of each child word on its own pseudo-random draw. Each child word is written back at the same address as the parent word it came from.

Two 16-bit thresholds set the probabilities. The crossover threshold is tested once per pair, when the run is accepted. The mutation threshold is tested once for every bit. Either parent may be flagged as the elite individual. That parent is then copied to its child untouched, and the exchange of words is switched off for the pair. Randomness comes from a bank of 32-bit Galois LFSR lanes. All lanes derive from one software-loadable seed. A zero seed is treated as a fixed nonzero default.

Top module: `gbu_breed_unit`

## Requirements
- R1: Crossover never splits a word. For every address, each child word is one parent's whole word, and when child A takes parent B's word, child B takes parent A's word at that address.
- R2: At start the pair is tested once: crossover is enabled when a fresh 16-bit draw is below `cross_thresh`, or always when `cross_thresh` is 16'hFFFF. With `cross_thresh` = 0 the children equal the parents before mutation. With crossover enabled each address exchanges its words with probability 1/2.
- R3: A child bit is inverted when its own fresh 16-bit draw is below `mut_thresh`. A threshold of 0 never inverts a bit, and 16'hFFFF inverts every bit of a non-elite child.
- R4: With `mut_thresh` = 16'h8000 close to half of all child bits are inverted. With 16'h0100 very few are.
- R5: If `elite_a` (or `elite_b`) is high at start, child A (or B) is an exact copy of parent A (or B). No words are exchanged for that pair, and the other child is still mutated.
- R6: A run reads addresses 0 to GENO_WORDS-1 in order, one per clock, with `rd_en` high. Parent data is expected one clock after the read. Each child word is presented with `wr_en` one clock after its parent data, at the same address, in increasing order, exactly GENO_WORDS writes per run.
- R7: `done` is high for exactly one clock, the clock right after the write of the last address.
- R8: After reset, and after `seed_load` with `seed_val` = 0, the generator holds the state derived from the default seed 32'h1ACEB00C. Equal generator states and equal inputs give identical children.
- R9: After reset `rd_en`, `wr_en` and `done` are low.
- R10: A `start` pulse while a run is in flight is ignored. The run still writes GENO_WORDS words and raises `done` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_load | input | 1 | Load the generator from `seed_val` |
| seed_val | input | 32 | Generator seed, 0 selects the default seed |
| start | input | 1 | Start a run when idle |
| elite_a | input | 1 | Parent A is elite, sampled at start |
| elite_b | input | 1 | Parent B is elite, sampled at start |
| mut_thresh | input | 16 | Per-bit mutation threshold, sampled at start |
| cross_thresh | input | 16 | Per-pair crossover threshold, tested at start |
| rd_en | output | 1 | Parent read strobe |
| rd_addr | output | $clog2(GENO_WORDS) | Parent word address |
| par_a_data | input | WORD_W | Parent A word, one clock after the read |
| par_b_data | input | WORD_W | Parent B word, one clock after the read |
| wr_en | output | 1 | Child write strobe |
| wr_addr | output | $clog2(GENO_WORDS) | Child word address |
| child_a_data | output | WORD_W | Child A word |
| child_b_data | output | WORD_W | Child B word |
| done | output | 1 | One-clock end-of-run pulse |

## Verification
The bench builds the unit with GENO_WORDS = 48 and keeps the 16-bit word. A full run is then about fifty clocks, so many runs fit, each with its own thresholds, elite flags and seeds. Forty-eight words give 1536 child bits per run, enough for the word-exchange share and the mid-threshold inversion share to be held to wide statistical bounds. The all-ones and zero threshold settings make the results exact and fully predictable, so the elite copy, the inversion and the straight copy are compared word for word.

// File: rtl/gbu_pkg.sv
// Shared constants and helper functions of the breed unit.
// Assumes a 32-bit right-shifting Galois LFSR and 16-bit thresholds.
package gbu_pkg;

    localparam int unsigned RNG_W = 32;
    localparam int unsigned THR_W = 16;
    localparam logic [RNG_W-1:0] RNG_POLY    = 32'hD000_0001;
    localparam logic [RNG_W-1:0] RNG_DEFAULT = 32'h1ACE_B00C;
    localparam logic [RNG_W-1:0] LANE_SPREAD = 32'h9E37_79B9;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;

    // One Galois step; a nonzero state stays nonzero.
    function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
        return s[0] ? ((s >> 1) ^ RNG_POLY) : (s >> 1);
    endfunction

    // Several unrolled steps, so that each draw has fresh low bits.
    function automatic logic [RNG_W-1:0] rng_advance(input logic [RNG_W-1:0] s,
                                                     input int unsigned n);
        logic [RNG_W-1:0] t;
        t = s;
        for (int unsigned k = 0; k < n; k++) t = rng_step(t);
        return t;
    endfunction

    // Per-lane start state spread from a base seed, never zero.
    function automatic logic [RNG_W-1:0] lane_seed(input logic [RNG_W-1:0] base,
                                                   input int unsigned lane);
        logic [RNG_W-1:0] v;
        v = base ^ (LANE_SPREAD * RNG_W'(lane + 1));
        if (v == '0) v = RNG_DEFAULT;
        return v;
    endfunction

    // Event test: draw below threshold, all-ones threshold always hits.
    function automatic logic thr_hit(input logic [THR_W-1:0] r,
                                     input logic [THR_W-1:0] t);
        return (&t) || (r < t);
    endfunction

endpackage

// File: rtl/gbu_rng_bank.sv
// Bank of independent 32-bit Galois LFSR lanes.
// Each lane advances STEPS positions per enabled clock. A zero seed
// value is replaced by the package default. Reset equals a zero seed load.
module gbu_rng_bank
    import gbu_pkg::*;
#(
    parameter int unsigned LANES = 33,
    parameter int unsigned STEPS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        seed_load,
    input  logic [RNG_W-1:0]            seed_val,
    input  logic                        step_en,
    output logic [LANES-1:0][RNG_W-1:0] lane_q
);

    logic [RNG_W-1:0] base_seed;

    // Substitute the default for an all-zero seed.
    assign base_seed = (seed_val == '0) ? RNG_DEFAULT : seed_val;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // Lane register: reset, reload or advance.
            always_ff @(posedge clk) begin
                if (!rst_n)          lane_q[g] <= lane_seed(RNG_DEFAULT, g);
                else if (seed_load)  lane_q[g] <= lane_seed(base_seed, g);
                else if (step_en)    lane_q[g] <= rng_advance(lane_q[g], STEPS);
            end

            // R8
            lane_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                lane_q[g] != '0);
        end
    endgenerate

endmodule

// File: rtl/gbu_word_mixer.sv
// Combinational word stage: whole-word exchange then per-bit inversion.
// Assumes each bit has its own THR_W-bit draw per child. A kept (elite)
// child receives no inversion; the caller suppresses the exchange.
module gbu_word_mixer
    import gbu_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic [WORD_W-1:0]            par_a,
    input  logic [WORD_W-1:0]            par_b,
    input  logic                         swap,
    input  logic                         keep_a,
    input  logic                         keep_b,
    input  logic [THR_W-1:0]             mut_thresh,
    input  logic [WORD_W-1:0][THR_W-1:0] rand_a,
    input  logic [WORD_W-1:0][THR_W-1:0] rand_b,
    output logic [WORD_W-1:0]            child_a,
    output logic [WORD_W-1:0]            child_b
);

    logic [WORD_W-1:0] pick_a;
    logic [WORD_W-1:0] pick_b;
    logic [WORD_W-1:0] flip_a;
    logic [WORD_W-1:0] flip_b;

    // Whole-word choice of source parent.
    assign pick_a = swap ? par_b : par_a;
    assign pick_b = swap ? par_a : par_b;

    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            // Per-bit inversion decision for each child.
            assign flip_a[b] = !keep_a && thr_hit(rand_a[b], mut_thresh);
            assign flip_b[b] = !keep_b && thr_hit(rand_b[b], mut_thresh);
        end
    endgenerate

    // Apply the inversion masks.
    assign child_a = pick_a ^ flip_a;
    assign child_b = pick_b ^ flip_b;

endmodule

// File: rtl/gbu_seq_ctrl.sv
// Run sequencer: address counter, read/compute/write valid pipeline and
// end-of-run pulse. Assumes the parent buffers return data one clock
// after the read. A start is only taken when the pipeline is empty.
module gbu_seq_ctrl
    import gbu_pkg::*;
#(
    parameter int unsigned DEPTH = 320,
    parameter int unsigned AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          start_ok,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          s1_vld,
    output logic [AW-1:0] s1_addr,
    output logic          wr_vld,
    output logic [AW-1:0] wr_addr,
    output logic          done
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    seq_state_e    st_q;
    logic [AW-1:0] ptr_q;

    // Accept a start only when fully idle.
    assign start_ok = start && (st_q == ST_IDLE) && !s1_vld && !wr_vld;
    assign rd_en    = (st_q == ST_RUN);
    assign rd_addr  = ptr_q;

    // State and address counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ptr_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start_ok) begin
                    st_q  <= ST_RUN;
                    ptr_q <= '0;
                end
                ST_RUN: if (ptr_q == LAST) begin
                    st_q  <= ST_IDLE;
                    ptr_q <= '0;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Valid and address pipeline behind the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_addr <= '0;
            wr_vld  <= 1'b0;
            wr_addr <= '0;
            done    <= 1'b0;
        end else begin
            s1_vld  <= rd_en;
            s1_addr <= rd_addr;
            wr_vld  <= s1_vld;
            wr_addr <= s1_addr;
            done    <= wr_vld && (wr_addr == LAST);
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    rd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + 1'b1);

    // R6
    rd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (rd_addr == LAST) |=> !rd_en);

    // R6
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rd_addr <= LAST);

endmodule

// File: rtl/gbu_breed_unit.sv
// Top of the breed unit. Streams two parent genotypes, exchanges whole
// words when the per-pair test passes, inverts bits by threshold and
// writes two children. Elite parents are passed through. Assumes parent
// data arrives one clock after rd_en; controls are sampled at start.
module gbu_breed_unit
    import gbu_pkg::*;
#(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned GENO_WORDS = 320,
    localparam int unsigned AW        = $clog2(GENO_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic [RNG_W-1:0]  seed_val,
    input  logic              start,
    input  logic              elite_a,
    input  logic              elite_b,
    input  logic [THR_W-1:0]  mut_thresh,
    input  logic [THR_W-1:0]  cross_thresh,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] par_a_data,
    input  logic [WORD_W-1:0] par_b_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] child_a_data,
    output logic [WORD_W-1:0] child_b_data,
    output logic              done
);

    localparam int unsigned LANES   = 2 * WORD_W + 1;
    localparam int unsigned X_LANE  = 2 * WORD_W;

    logic                         start_ok;
    logic                         s1_vld;
    logic [AW-1:0]                s1_addr;
    logic [LANES-1:0][RNG_W-1:0]  lane_q;
    logic [WORD_W-1:0][THR_W-1:0] rand_a;
    logic [WORD_W-1:0][THR_W-1:0] rand_b;
    logic                         keep_a_q;
    logic                         keep_b_q;
    logic                         cross_q;
    logic [THR_W-1:0]             mut_thr_q;
    logic                         swap;
    logic [WORD_W-1:0]            mix_a;
    logic [WORD_W-1:0]            mix_b;

    gbu_seq_ctrl #(
        .DEPTH (GENO_WORDS),
        .AW    (AW)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_ok (start_ok),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .s1_vld   (s1_vld),
        .s1_addr  (s1_addr),
        .wr_vld   (wr_en),
        .wr_addr  (wr_addr),
        .done     (done)
    );

    gbu_rng_bank #(
        .LANES (LANES),
        .STEPS (THR_W)
    ) rng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .seed_val  (seed_val),
        .step_en   (start_ok || s1_vld),
        .lane_q    (lane_q)
    );

    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_draw
            // Route one lane per child bit.
            assign rand_a[b] = lane_q[b][THR_W-1:0];
            assign rand_b[b] = lane_q[WORD_W+b][THR_W-1:0];
        end
    endgenerate

    // Per-word exchange bit from the crossover lane.
    assign swap = cross_q && lane_q[X_LANE][THR_W];

    gbu_word_mixer #(
        .WORD_W (WORD_W)
    ) mix_i (
        .par_a      (par_a_data),
        .par_b      (par_b_data),
        .swap       (swap),
        .keep_a     (keep_a_q),
        .keep_b     (keep_b_q),
        .mut_thresh (mut_thr_q),
        .rand_a     (rand_a),
        .rand_b     (rand_b),
        .child_a    (mix_a),
        .child_b    (mix_b)
    );

    // Sample run controls and test the pair once at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_a_q  <= 1'b0;
            keep_b_q  <= 1'b0;
            cross_q   <= 1'b0;
            mut_thr_q <= '0;
        end else if (start_ok) begin
            keep_a_q  <= elite_a;
            keep_b_q  <= elite_b;
            mut_thr_q <= mut_thresh;
            cross_q   <= !(elite_a || elite_b) &&
                         thr_hit(lane_q[X_LANE][THR_W-1:0], cross_thresh);
        end
    end

    // Child word output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            child_a_data <= '0;
            child_b_data <= '0;
        end else if (s1_vld) begin
            child_a_data <= mix_a;
            child_b_data <= mix_b;
        end
    end

    // R5
    elite_a_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && keep_a_q |-> child_a_data == $past(par_a_data));

    // R5
    elite_b_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && keep_b_q |-> child_b_data == $past(par_b_data));

    // R5
    elite_no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_a_q || keep_b_q) |-> !cross_q);

    // R1
    word_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (mut_thr_q == '0) |->
        (child_a_data ^ child_b_data) == ($past(par_a_data) ^ $past(par_b_data)));

    // R6
    wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 1'b1);

endmodule

// File: tb/gbu_breed_unit_tb_top.sv
// Directed bench for gbu_breed_unit, one task per scenario.
module gbu_breed_unit_tb_top;

    localparam int unsigned W  = 16;
    localparam int unsigned N  = 48;
    localparam int unsigned AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seed_load = 1'b0;
    logic [31:0]   seed_val = '0;
    logic          start = 1'b0;
    logic          elite_a = 1'b0;
    logic          elite_b = 1'b0;
    logic [15:0]   mut_thresh = '0;
    logic [15:0]   cross_thresh = '0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [W-1:0]  par_a_data;
    logic [W-1:0]  par_b_data;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [W-1:0]  child_a_data;
    logic [W-1:0]  child_b_data;
    logic          done;

    gbu_breed_unit #(.WORD_W(W), .GENO_WORDS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
        .start(start), .elite_a(elite_a), .elite_b(elite_b),
        .mut_thresh(mut_thresh), .cross_thresh(cross_thresh),
        .rd_en(rd_en), .rd_addr(rd_addr), .par_a_data(par_a_data),
        .par_b_data(par_b_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .child_a_data(child_a_data), .child_b_data(child_b_data), .done(done)
    );

    always #4 clk = ~clk;

    logic [W-1:0] mem_a [N];
    logic [W-1:0] mem_b [N];
    logic [W-1:0] got_a [N];
    logic [W-1:0] got_b [N];
    logic [W-1:0] keep_a [N];
    logic [W-1:0] keep_b [N];
    int cyc = 0, wr_count = 0, done_count = 0, seq_err = 0;
    int last_wr_cyc = 0, done_cyc = 0;
    int n_chk = 0, n_fail = 0;
    logic prev_wr = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    // Parent buffers with one clock read latency.
    always @(posedge clk) begin
        if (rd_en) begin
            par_a_data <= mem_a[rd_addr];
            par_b_data <= mem_b[rd_addr];
        end
    end

    // Capture child writes and end pulses.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        prev_wr <= wr_en;
        prev_addr <= wr_addr;
        if (wr_en) begin
            got_a[wr_addr] <= child_a_data;
            got_b[wr_addr] <= child_b_data;
            wr_count <= wr_count + 1;
            if (prev_wr && wr_addr != prev_addr + 1'b1) seq_err <= seq_err + 1;
            if (!prev_wr && wr_addr != '0) seq_err <= seq_err + 1;
            if (wr_addr == AW'(N - 1)) last_wr_cyc <= cyc;
        end
        if (done) begin
            done_count <= done_count + 1;
            done_cyc <= cyc;
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [15:0] salt);
        for (int i = 0; i < N; i++) begin
            mem_a[i] = 16'((i + 1) * 40503) ^ salt;
            mem_b[i] = mem_a[i] ^ 16'hA5C3 ^ 16'(i);
        end
    endtask

    task automatic load_seed(input logic [31:0] s);
        @(negedge clk);
        seed_val = s;
        seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    // One run; checks write count, order, and done timing (R6, R7, R10).
    task automatic run_op(input logic ea, input logic eb, input logic [15:0] mt,
                          input logic [15:0] ct, input bit restart);
        int wc0, dc0, seq0, waited;
        wc0 = wr_count;
        dc0 = done_count;
        seq0 = seq_err;
        @(negedge clk);
        elite_a = ea;
        elite_b = eb;
        mut_thresh = mt;
        cross_thresh = ct;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done_count == dc0 && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        repeat (4) @(negedge clk);
        chk(wr_count - wc0 == N, "R6", "write count", wr_count - wc0, N);
        chk(seq_err == seq0, "R6", "write order errors", seq_err - seq0, 0);
        chk(done_count - dc0 == 1, restart ? "R10" : "R7", "done pulses",
            done_count - dc0, 1);
        chk(done_cyc == last_wr_cyc + 1, "R7", "done cycle after last write",
            done_cyc - last_wr_cyc, 1);
    endtask

    task automatic t_reset();
        chk(rd_en == 1'b0, "R9", "rd_en after reset", int'(rd_en), 0);
        chk(wr_en == 1'b0, "R9", "wr_en after reset", int'(wr_en), 0);
        chk(done == 1'b0, "R9", "done after reset", int'(done), 0);
    endtask

    task automatic t_copy();
        int bad = 0;
        fill(16'h1111);
        run_op(1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0);
        for (int i = 0; i < N; i++)
            if (got_a[i] != mem_a[i] || got_b[i] != mem_b[i]) bad++;
        chk(bad == 0, "R2", "straight copy mismatches", bad, 0);
        chk(bad == 0, "R3", "zero threshold flips", bad, 0);
    endtask

    task automatic t_invert();
        int bad = 0;
        fill(16'h2E2E);
        run_op(1'b0, 1'b0, 16'hFFFF, 16'h0000, 1'b0);
        for (int i = 0; i < N; i++)
            if (got_a[i] != ~mem_a[i] || got_b[i] != ~mem_b[i]) bad++;
        chk(bad == 0, "R3", "full threshold inversion mismatches", bad, 0);
    endtask

    task automatic t_cross();
        int bad = 0, swaps = 0;
        fill(16'h3C3C);
        run_op(1'b0, 1'b0, 16'h0000, 16'hFFFF, 1'b0);
        for (int i = 0; i < N; i++) begin
            if (got_a[i] == mem_b[i] && got_b[i] == mem_a[i]) swaps++;
            else if (!(got_a[i] == mem_a[i] && got_b[i] == mem_b[i])) bad++;
        end
        chk(bad == 0, "R1", "split or unpaired words", bad, 0);
        chk(swaps >= N / 5 && swaps <= 4 * N / 5, "R2", "exchanged words", swaps, N / 2);
    endtask

    task automatic t_rate();
        int flips = 0;
        fill(16'h4747);
        run_op(1'b0, 1'b0, 16'h8000, 16'h0000, 1'b0);
        for (int i = 0; i < N; i++)
            flips += $countones(got_a[i] ^ mem_a[i]) + $countones(got_b[i] ^ mem_b[i]);
        chk(flips >= N * 32 * 35 / 100 && flips <= N * 32 * 65 / 100, "R4",
            "flips at half threshold", flips, N * 16);
        flips = 0;
        run_op(1'b0, 1'b0, 16'h0100, 16'h0000, 1'b0);
        for (int i = 0; i < N; i++)
            flips += $countones(got_a[i] ^ mem_a[i]) + $countones(got_b[i] ^ mem_b[i]);
        chk(flips <= N * 32 / 20, "R4", "flips at low threshold", flips, N * 32 / 256);
    endtask

    task automatic t_elite();
        int bad = 0;
        fill(16'h5A5A);
        run_op(1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0);
        for (int i = 0; i < N; i++)
            if (got_a[i] != mem_a[i] || got_b[i] != ~mem_b[i]) bad++;
        chk(bad == 0, "R5", "elite A run mismatches", bad, 0);
        bad = 0;
        run_op(1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0);
        for (int i = 0; i < N; i++)
            if (got_b[i] != mem_b[i] || got_a[i] != ~mem_a[i]) bad++;
        chk(bad == 0, "R5", "elite B run mismatches", bad, 0);
    endtask

    task automatic t_seed();
        int bad = 0, bad2 = 0;
        fill(16'h6B6B);
        load_seed(32'h0000_0000);
        run_op(1'b0, 1'b0, 16'h8000, 16'hFFFF, 1'b0);
        for (int i = 0; i < N; i++) begin
            keep_a[i] = got_a[i];
            keep_b[i] = got_b[i];
        end
        load_seed(32'h1ACE_B00C);
        run_op(1'b0, 1'b0, 16'h8000, 16'hFFFF, 1'b0);
        for (int i = 0; i < N; i++)
            if (got_a[i] != keep_a[i] || got_b[i] != keep_b[i]) bad++;
        chk(bad == 0, "R8", "zero seed vs default seed mismatches", bad, 0);
        load_seed(32'h0000_0000);
        run_op(1'b0, 1'b0, 16'h8000, 16'hFFFF, 1'b0);
        for (int i = 0; i < N; i++)
            if (got_a[i] != keep_a[i] || got_b[i] != keep_b[i]) bad2++;
        chk(bad2 == 0, "R8", "repeat run mismatches", bad2, 0);
    endtask

    task automatic t_restart();
        int bad = 0;
        fill(16'h7070);
        run_op(1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1);
        for (int i = 0; i < N; i++)
            if (got_a[i] != mem_a[i] || got_b[i] != mem_b[i]) bad++;
        chk(bad == 0, "R10", "data after ignored start", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_copy();
        t_invert();
        t_cross();
        t_rate();
        t_elite();
        t_seed();
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule